// File: doc/BRIEF.md
# Banked Stack Pointer and Privilege Controller

This block keeps the execution context of a small processor core: a two-bit control word, a main stack pointer and a process stack pointer. It follows whether the core runs in thread mode or handler mode by counting exception entry and exit strobes. From the control word and the mode it derives which stack pointer bank is live and whether the running code is privileged.

Register requests arrive on one port. Each request carries a select code, a write flag, write data and the requester's privilege. The live stack pointer can be reached through a shared port. Each bank can also be reached directly. A write that the block refuses for lack of privilege has no effect, and a reject flag is raised for one cycle.

Top module: `stack_bank_ctrl`

## Requirements
- R1: Reset loads the main pointer from `reset_vector` with bits [1:0] cleared. It clears the control word and the process pointer. After reset the block is in thread mode and privileged, and the main pointer is live.
- R2: In thread mode, control bit 1 selects the live bank: 0 selects main and 1 selects process. `sp_active` shows the live bank's value.
- R3: In handler mode the main pointer is live whatever control bit 1 holds.
- R4: In thread mode, `priv_level` is the inverse of control bit 0. In handler mode `priv_level` is always 1.
- R5: A write to the control word (select 2'b00) with `req_priv`=0 leaves the control word unchanged. `rdata` reads the control word in bits [1:0], with zeros above.
- R6: Select 2'b01 reads and writes the live bank at any privilege. The other bank is left unchanged.
- R7: Selects 2'b10 (main) and 2'b11 (process) reach a bank whether or not it is live. A write to either from `req_priv`=0 is ignored.
- R8: Every stored stack pointer value has bits [1:0] equal to zero.
- R9: `exc_enter` raises the nesting depth and `exc_exit` lowers it. Handler mode holds while the depth is nonzero. An entry at the maximum depth, 2**NEST_W-1, is ignored. An exit at depth zero is ignored.
- R10: An ignored write raises `wr_reject` for exactly the one cycle after the request edge. An accepted write does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vector | input | 32 | Initial main pointer value |
| exc_enter | input | 1 | Exception entry strobe |
| exc_exit | input | 1 | Exception return strobe |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 00 control, 01 live pointer, 10 main, 11 process |
| req_priv | input | 1 | Requester is privileged |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `req_sel`, combinational |
| sp_active | output | 32 | Live stack pointer |
| use_process | output | 1 | Process bank is live |
| priv_level | output | 1 | Current code is privileged |
| handler_mode | output | 1 | Handler mode active |
| wr_reject | output | 1 | Previous write was refused |

## Verification
The situation hardest to reach from the ports is a nonzero control word combined with handler mode. There, both the bank choice and the privilege must override the stored bits while the bits themselves stay put. The stimulus programs every control value with privileged writes and enters and leaves an exception for each one. It also writes the shared pointer port inside the handler with the process bank selected, which must land in the main bank. Nesting is driven past its ceiling and unwound below zero so that both ignored strobes can be seen on `handler_mode`.

// File: rtl/stack_bank_pkg.sv
package stack_bank_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'b00,
        SEL_ACTIVE = 2'b01,
        SEL_MAIN   = 2'b10,
        SEL_PROC   = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic proc_in_thread;  // bit 1
        logic thread_unpriv;   // bit 0
    } ctrl_word_t;

    typedef struct packed {
        logic we_ctrl;
        logic we_main;
        logic we_proc;
        logic reject;
    } wr_grant_t;

    function automatic logic [31:0] word_align(input logic [31:0] v);
        return {v[31:2], 2'b00};
    endfunction

endpackage

// File: rtl/sbc_mode_track.sv
module sbc_mode_track #(
    parameter int NEST_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic exc_enter,
    input  logic exc_exit,
    output logic handler
);
    localparam logic [NEST_W-1:0] DEPTH_MAX = {NEST_W{1'b1}};

    logic [NEST_W-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
        end else if (exc_enter && !exc_exit && depth_q != DEPTH_MAX) begin
            depth_q <= depth_q + 1'b1;
        end else if (exc_exit && !exc_enter && depth_q != '0) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    assign handler = (depth_q != '0);

    p_exit_floor_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_exit && !exc_enter && depth_q == '0) |=> (depth_q == '0));
    p_enter_ceiling_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_enter && !exc_exit && depth_q == DEPTH_MAX) |=> (depth_q == DEPTH_MAX));
endmodule

// File: rtl/sbc_access_gate.sv
module sbc_access_gate
    import stack_bank_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  reg_sel_e    req_sel,
    input  logic        req_priv,
    input  logic        use_process,
    output wr_grant_t   grant
);
    always_comb begin
        grant = '0;
        if (req_valid && req_write) begin
            unique case (req_sel)
                SEL_CTRL: begin
                    grant.we_ctrl = req_priv;
                    grant.reject  = !req_priv;
                end
                SEL_ACTIVE: begin
                    grant.we_proc = use_process;
                    grant.we_main = !use_process;
                end
                SEL_MAIN: begin
                    grant.we_main = req_priv;
                    grant.reject  = !req_priv;
                end
                SEL_PROC: begin
                    grant.we_proc = req_priv;
                    grant.reject  = !req_priv;
                end
                default: grant = '0;
            endcase
        end
    end
endmodule

// File: rtl/sbc_bank_regs.sv
module sbc_bank_regs
    import stack_bank_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SP_W-1:0] reset_vector,
    input  wr_grant_t       grant,
    input  logic [SP_W-1:0] wdata,
    input  logic            raw_ctrl_write,
    input  logic            raw_priv,
    output ctrl_word_t      ctrl_q,
    output logic [SP_W-1:0] main_q,
    output logic [SP_W-1:0] proc_q,
    output logic            reject_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            main_q   <= word_align(reset_vector);
            proc_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            if (grant.we_ctrl) ctrl_q <= ctrl_word_t'(wdata[1:0]);
            if (grant.we_main) main_q <= word_align(wdata);
            if (grant.we_proc) proc_q <= word_align(wdata);
            reject_q <= grant.reject;
        end
    end

    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (raw_ctrl_write && !raw_priv) |=> $stable(ctrl_q));
    p_align_r8: assert property (@(posedge clk) disable iff (rst)
        (main_q[1:0] == 2'b00) && (proc_q[1:0] == 2'b00));
    p_single_bank_r6: assert property (@(posedge clk) disable iff (rst)
        !(grant.we_main && grant.we_proc));
endmodule

// File: rtl/stack_bank_ctrl.sv
module stack_bank_ctrl
    import stack_bank_pkg::*;
#(
    parameter int NEST_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] reset_vector,
    input  logic        exc_enter,
    input  logic        exc_exit,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_sel,
    input  logic        req_priv,
    input  logic [31:0] req_wdata,
    output logic [31:0] rdata,
    output logic [31:0] sp_active,
    output logic        use_process,
    output logic        priv_level,
    output logic        handler_mode,
    output logic        wr_reject
);
    localparam int SP_W = 32;

    reg_sel_e        sel;
    wr_grant_t       grant;
    ctrl_word_t      ctrl;
    logic [SP_W-1:0] main_sp;
    logic [SP_W-1:0] proc_sp;
    logic            ctrl_wr_raw;

    assign sel         = reg_sel_e'(req_sel);
    assign ctrl_wr_raw = req_valid && req_write && (sel == SEL_CTRL);

    sbc_mode_track #(.NEST_W(NEST_W)) i_mode (
        .clk       (clk),
        .rst       (rst),
        .exc_enter (exc_enter),
        .exc_exit  (exc_exit),
        .handler   (handler_mode)
    );

    sbc_access_gate i_gate (
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_sel     (sel),
        .req_priv    (req_priv),
        .use_process (use_process),
        .grant       (grant)
    );

    sbc_bank_regs #(.SP_W(SP_W)) i_regs (
        .clk            (clk),
        .rst            (rst),
        .reset_vector   (reset_vector),
        .grant          (grant),
        .wdata          (req_wdata),
        .raw_ctrl_write (ctrl_wr_raw),
        .raw_priv       (req_priv),
        .ctrl_q         (ctrl),
        .main_q         (main_sp),
        .proc_q         (proc_sp),
        .reject_q       (wr_reject)
    );

    assign use_process = !handler_mode && ctrl.proc_in_thread;
    assign priv_level  = handler_mode || !ctrl.thread_unpriv;
    assign sp_active   = use_process ? proc_sp : main_sp;

    always_comb begin
        unique case (sel)
            SEL_CTRL:   rdata = {{(SP_W-2){1'b0}}, ctrl};
            SEL_ACTIVE: rdata = sp_active;
            SEL_MAIN:   rdata = main_sp;
            SEL_PROC:   rdata = proc_sp;
            default:    rdata = '0;
        endcase
    end

    p_handler_main_r3: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> (sp_active == main_sp));
    p_handler_priv_r4: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> priv_level);
    p_reject_cause_r10: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> $past(req_valid && req_write && !req_priv && req_sel != 2'b01));
endmodule

// File: tb/test_stack_bank_ctrl.sv
module test_stack_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] reset_vector;
    logic        exc_enter, exc_exit;
    logic        req_valid, req_write, req_priv;
    logic [1:0]  req_sel;
    logic [31:0] req_wdata;
    logic [31:0] rdata, sp_active;
    logic        use_process, priv_level, handler_mode, wr_reject;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_main, exp_proc;
    logic [1:0]  exp_ctrl;
    logic        rej;

    always #4 clk = ~clk;

    stack_bank_ctrl #(.NEST_W(2)) i_stack_bank_ctrl (
        .clk(clk), .rst(rst), .reset_vector(reset_vector),
        .exc_enter(exc_enter), .exc_exit(exc_exit),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .req_priv(req_priv), .req_wdata(req_wdata), .rdata(rdata),
        .sp_active(sp_active), .use_process(use_process),
        .priv_level(priv_level), .handler_mode(handler_mode),
        .wr_reject(wr_reject)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic priv, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_priv = priv; req_wdata = d;
        @(negedge clk);
        rej = wr_reject;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        req_sel = sel;
        #1;
        v = rdata;
    endtask

    task automatic strobe(input logic en, input logic ex);
        @(negedge clk);
        exc_enter = en; exc_exit = ex;
        @(negedge clk);
        exc_enter = 1'b0; exc_exit = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reset_vector = 32'h2000_0403;
        exc_enter = 0; exc_exit = 0; req_valid = 0; req_write = 0;
        req_sel = 2'b00; req_priv = 0; req_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_main = 32'h2000_0400; exp_proc = 32'h0; exp_ctrl = 2'b00;

        // R1 / R8 reset state
        check("R1 sp_active", sp_active, exp_main);
        check("R1 priv", {31'b0, priv_level}, 32'd1);
        check("R1 handler", {31'b0, handler_mode}, 32'd0);
        check("R1 use_process", {31'b0, use_process}, 32'd0);
        rd(2'b00, v); check("R1 ctrl", v, 32'd0);
        rd(2'b11, v); check("R1 proc", v, 32'd0);

        // R7 / R8 direct bank writes, privileged
        wr(2'b10, 1'b1, 32'h1000_0007); exp_main = 32'h1000_0004;
        check("R10 no reject main", {31'b0, rej}, 32'd0);
        wr(2'b11, 1'b1, 32'h3000_0012); exp_proc = 32'h3000_0010;
        rd(2'b10, v); check("R8 main aligned", v, exp_main);
        rd(2'b11, v); check("R7 proc direct", v, exp_proc);

        // R2 R3 R4 sweep over all control values and both modes
        for (int c = 0; c < 4; c++) begin
            wr(2'b00, 1'b1, 32'(c)); exp_ctrl = 2'(c);
            check("R10 no reject ctrl", {31'b0, rej}, 32'd0);
            rd(2'b00, v); check("R5 ctrl readback", v, {30'b0, exp_ctrl});
            check("R2 use_process", {31'b0, use_process}, {31'b0, exp_ctrl[1]});
            check("R2 sp_active", sp_active, exp_ctrl[1] ? exp_proc : exp_main);
            check("R4 thread priv", {31'b0, priv_level}, {31'b0, ~exp_ctrl[0]});
            strobe(1'b1, 1'b0);
            check("R9 entered", {31'b0, handler_mode}, 32'd1);
            check("R3 handler main", sp_active, exp_main);
            check("R3 handler use_process", {31'b0, use_process}, 32'd0);
            check("R4 handler priv", {31'b0, priv_level}, 32'd1);
            rd(2'b00, v); check("R3 ctrl kept", v, {30'b0, exp_ctrl});
            strobe(1'b0, 1'b1);
            check("R9 left", {31'b0, handler_mode}, 32'd0);
        end

        // R5 unprivileged control write ignored (ctrl now 3)
        wr(2'b00, 1'b0, 32'h0);
        check("R10 reject ctrl", {31'b0, rej}, 32'd1);
        rd(2'b00, v); check("R5 ctrl unchanged", v, 32'd3);
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, wr_reject}, 32'd0);

        // R6 live-port write by unprivileged code goes to process bank
        wr(2'b01, 1'b0, 32'h4444_4441); exp_proc = 32'h4444_4440;
        check("R6 no reject", {31'b0, rej}, 32'd0);
        rd(2'b11, v); check("R6 proc written", v, exp_proc);
        rd(2'b10, v); check("R6 main untouched", v, exp_main);
        rd(2'b01, v); check("R6 live read", v, exp_proc);

        // R7 unprivileged direct bank writes rejected
        wr(2'b10, 1'b0, 32'hDEAD_BEE0);
        check("R7 reject main", {31'b0, rej}, 32'd1);
        rd(2'b10, v); check("R7 main kept", v, exp_main);
        wr(2'b11, 1'b0, 32'hDEAD_BEE0);
        check("R7 reject proc", {31'b0, rej}, 32'd1);
        rd(2'b11, v); check("R7 proc kept", v, exp_proc);

        // R3 / R6 live-port write in handler mode lands in main
        strobe(1'b1, 1'b0);
        wr(2'b01, 1'b1, 32'h5555_0006); exp_main = 32'h5555_0004;
        rd(2'b10, v); check("R3 handler write main", v, exp_main);
        rd(2'b11, v); check("R6 proc untouched", v, exp_proc);
        strobe(1'b0, 1'b1);
        check("R2 back to process", sp_active, exp_proc);

        // R9 nesting ceiling and floor (max depth 3)
        for (int i = 0; i < 4; i++) strobe(1'b1, 1'b0);
        for (int i = 0; i < 2; i++) strobe(1'b0, 1'b1);
        check("R9 depth 1 after saturate", {31'b0, handler_mode}, 32'd1);
        strobe(1'b0, 1'b1);
        check("R9 depth 0", {31'b0, handler_mode}, 32'd0);
        strobe(1'b0, 1'b1);
        check("R9 floor", {31'b0, handler_mode}, 32'd0);
        strobe(1'b1, 1'b0);
        check("R9 re-enter after floor", {31'b0, handler_mode}, 32'd1);
        strobe(1'b1, 1'b1);
        check("R9 simultaneous", {31'b0, handler_mode}, 32'd1);
        strobe(1'b0, 1'b1);
        check("R9 final exit", {31'b0, handler_mode}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule